// File: doc/BRIEF.md
# Debug Communications Mailbox with Sticky Status

This block carries 32-bit words in both directions between an external debugger and a processor core. The receive slot carries words from the debugger to the core, and the transmit slot carries words from the core to the debugger. Each slot has a full flag. Only the accesses from the two sides move these flags: the writer of a slot sets its flag, and the reader on the other side clears it. A core write to a transmit slot that is already full replaces the stored word. A core read of an empty receive slot returns the stale stored word.

A sticky retire-detect flag is set by any pulse of the one-cycle instruction-retire strobe. It stays set until the debugger writes a 1 to the clear bit of the run-control register. The debugger reads all three flags in one status word. Every other status bit reads as zero.

Each of the three flags is an instance of the same two-state machine. Its states are FLAG_CLR (reset state) and FLAG_SET, and it has two transitions:
- SET_EVENT moves FLAG_CLR to FLAG_SET.
- CLEAR_EVENT moves FLAG_SET to FLAG_CLR, but only when no set event occurs in the same cycle.

A set event in FLAG_SET keeps the flag in FLAG_SET, so a set always wins over a clear.

Debugger register select on `dbg_sel`:
- 0: receive data
- 1: transmit data
- 2: status word
- 3: run-control

Status word bit positions:
- bit 30: receive-full
- bit 29: transmit-full
- bit 25: retire-detect

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the status word is zero, both data slots hold zero, and all three flags are clear.
- R2: A debugger write with `dbg_sel`=0 loads the receive slot and sets status bit 30. A debugger read with `dbg_sel`=0 returns the receive slot. A debugger read with `dbg_sel`=3, and any cycle without a debugger read, gives `dbg_rdata` = 0.
- R3: A core read (`core_valid`=1, `core_write`=0) clears status bit 30 on the next edge. `core_rdata` always shows the receive slot, so after the flag clears it still shows the stale word.
- R4: A core write loads the transmit slot and sets status bit 29.
- R5: A debugger read with `dbg_sel`=1 returns the transmit slot in the same cycle and clears status bit 29 on the next edge.
- R6: A core write while status bit 29 is set replaces the stored transmit word, and bit 29 stays set.
- R7: A cycle with `retire_pulse`=1 sets status bit 25, and the bit stays set without further pulses.
- R8: A debugger write with `dbg_sel`=3 clears status bit 25 only when data bit 3 is 1. Data bit 3 = 0 leaves bit 25 unchanged.
- R9: A debugger write with `dbg_sel`=2 changes no flag and no data slot.
- R10: Status bits other than 30, 29 and 25 always read as zero, including bits 31 and 28:26.
- R11: When a set event and a clear event for the same flag fall in one cycle, the flag ends set. The receive and transmit slots keep the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_valid | input | 1 | Debugger access strobe |
| dbg_write | input | 1 | Debugger access is a write when 1 |
| dbg_sel | input | 2 | Debugger register select (0 rx, 1 tx, 2 status, 3 run-control) |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, combinational |
| core_valid | input | 1 | Core access strobe |
| core_write | input | 1 | Core access is a write (to tx) when 1, a read (of rx) when 0 |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Receive slot contents |
| retire_pulse | input | 1 | One-cycle instruction-retire strobe |
| status_word | output | 32 | Assembled status word |

## Verification
A flag machine in the wrong state shows on `status_word` in the cycle right after the edge that moved it. A debugger read of the status word shows it in that same cycle. A wrong data slot shows on `core_rdata` immediately, or on `dbg_rdata` at the next transmit read. The bench therefore compares all three outputs against a behavioural model on every clock, so a fault is seen at most one access after it is made. The same-cycle set/clear collisions get their own directed cycles and are also hit repeatedly by random traffic.

// File: rtl/dbg_mbx_pkg.sv
package dbg_mbx_pkg;

    typedef enum logic {
        FLAG_CLR = 1'b0,
        FLAG_SET = 1'b1
    } flag_state_t;

    typedef enum logic [1:0] {
        SEL_RX     = 2'd0,
        SEL_TX     = 2'd1,
        SEL_STAT   = 2'd2,
        SEL_RUNCTL = 2'd3
    } dbg_sel_t;

    localparam int STAT_W         = 32;
    localparam int N_FLAGS        = 3;
    localparam int IDX_RX         = 0;
    localparam int IDX_TX         = 1;
    localparam int IDX_ADV        = 2;
    localparam int N_SLOTS        = 2;
    localparam int STAT_RXF_BIT   = 30;
    localparam int STAT_TXF_BIT   = 29;
    localparam int STAT_ADV_BIT   = 25;
    localparam int RUNCTL_CLR_BIT = 3;

endpackage

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import dbg_mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic is_set
);

    flag_state_t state_q;
    flag_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_CLR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: SET_EVENT, CLEAR_EVENT (set has priority)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLR: if (set_ev)                state_d = FLAG_SET;
            FLAG_SET: if (clr_ev && !set_ev)     state_d = FLAG_CLR;
        endcase
    end

    // Output
    always_comb begin
        is_set = (state_q == FLAG_SET);
    end

endmodule

// File: rtl/mbx_data_reg.sv
module mbx_data_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/mbx_status_pack.sv
module mbx_status_pack
    import dbg_mbx_pkg::*;
(
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic              adv_seen,
    output logic [STAT_W-1:0] word
);

    always_comb begin
        word               = '0;
        word[STAT_RXF_BIT] = rx_full;
        word[STAT_TXF_BIT] = tx_full;
        word[STAT_ADV_BIT] = adv_seen;
    end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_valid,
    input  logic              dbg_write,
    input  logic [1:0]        dbg_sel,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    input  logic              core_valid,
    input  logic              core_write,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              retire_pulse,
    output logic [STAT_W-1:0] status_word
);

    localparam int CMP_W = (DATA_W < STAT_W) ? DATA_W : STAT_W;

    logic              dbg_wr;
    logic              dbg_rd;
    logic              core_wr;
    logic              core_rd;
    logic [N_FLAGS-1:0] flag_set_ev;
    logic [N_FLAGS-1:0] flag_clr_ev;
    logic [N_FLAGS-1:0] flag_q;
    logic [N_SLOTS-1:0] slot_load;
    logic [DATA_W-1:0] slot_din  [N_SLOTS];
    logic [DATA_W-1:0] slot_dout [N_SLOTS];

    always_comb begin
        dbg_wr  = dbg_valid && dbg_write;
        dbg_rd  = dbg_valid && !dbg_write;
        core_wr = core_valid && core_write;
        core_rd = core_valid && !core_write;
    end

    // Event routing for the three flag machines and two slots
    always_comb begin
        flag_set_ev[IDX_RX]  = dbg_wr && (dbg_sel == SEL_RX);
        flag_clr_ev[IDX_RX]  = core_rd;
        flag_set_ev[IDX_TX]  = core_wr;
        flag_clr_ev[IDX_TX]  = dbg_rd && (dbg_sel == SEL_TX);
        flag_set_ev[IDX_ADV] = retire_pulse;
        flag_clr_ev[IDX_ADV] = dbg_wr && (dbg_sel == SEL_RUNCTL)
                               && dbg_wdata[RUNCTL_CLR_BIT];
        slot_load[IDX_RX]    = flag_set_ev[IDX_RX];
        slot_din[IDX_RX]     = dbg_wdata;
        slot_load[IDX_TX]    = flag_set_ev[IDX_TX];
        slot_din[IDX_TX]     = core_wdata;
    end

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        mbx_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (flag_set_ev[f]),
            .clr_ev (flag_clr_ev[f]),
            .is_set (flag_q[f])
        );
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        mbx_data_reg #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_load[s]),
            .din   (slot_din[s]),
            .dout  (slot_dout[s])
        );
    end

    mbx_status_pack u_stat (
        .rx_full  (flag_q[IDX_RX]),
        .tx_full  (flag_q[IDX_TX]),
        .adv_seen (flag_q[IDX_ADV]),
        .word     (status_word)
    );

    // Read paths
    always_comb begin
        core_rdata = slot_dout[IDX_RX];
        dbg_rdata  = '0;
        if (dbg_rd) begin
            unique case (dbg_sel)
                SEL_RX:     dbg_rdata = slot_dout[IDX_RX];
                SEL_TX:     dbg_rdata = slot_dout[IDX_TX];
                SEL_STAT:   dbg_rdata[CMP_W-1:0] = status_word[CMP_W-1:0];
                SEL_RUNCTL: dbg_rdata = '0;
                default:    dbg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk
    import dbg_mbx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_valid,
    input logic        dbg_write,
    input logic [1:0]  dbg_sel,
    input logic        dbg_wbit3,
    input logic        core_valid,
    input logic        core_write,
    input logic        retire_pulse,
    input logic [31:0] status_word
);

    logic rx_set, rx_clr, tx_set, tx_clr, adv_clr, stat_wr;

    always_comb begin
        rx_set  = dbg_valid && dbg_write && (dbg_sel == SEL_RX);
        rx_clr  = core_valid && !core_write;
        tx_set  = core_valid && core_write;
        tx_clr  = dbg_valid && !dbg_write && (dbg_sel == SEL_TX);
        adv_clr = dbg_valid && dbg_write && (dbg_sel == SEL_RUNCTL) && dbg_wbit3;
        stat_wr = dbg_valid && dbg_write && (dbg_sel == SEL_STAT);
    end

    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> status_word[STAT_RXF_BIT]); // R2
    AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_set) |=> !status_word[STAT_RXF_BIT]); // R3
    AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> status_word[STAT_TXF_BIT]); // R4
    AST_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_set) |=> !status_word[STAT_TXF_BIT]); // R5
    AST_ADV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        retire_pulse |=> status_word[STAT_ADV_BIT]); // R7
    AST_ADV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_clr && !retire_pulse) |=> !status_word[STAT_ADV_BIT]); // R8
    AST_STAT_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !retire_pulse && !core_valid) |=> $stable(status_word)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 32'h9DFF_FFFF) == 32'h0); // R10
    AST_ADV_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_pulse && adv_clr) |=> status_word[STAT_ADV_BIT]); // R11

endmodule

bind dbg_mailbox dbg_mailbox_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_valid    (dbg_valid),
    .dbg_write    (dbg_write),
    .dbg_sel      (dbg_sel),
    .dbg_wbit3    (dbg_wdata[3]),
    .core_valid   (core_valid),
    .core_write   (core_write),
    .retire_pulse (retire_pulse),
    .status_word  (status_word)
);

// File: tb/test_dbg_mailbox.sv
`timescale 1ns/1ps
module test_dbg_mailbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_valid = 1'b0;
    logic        dbg_write = 1'b0;
    logic [1:0]  dbg_sel = 2'd0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        core_valid = 1'b0;
    logic        core_write = 1'b0;
    logic [31:0] core_wdata = '0;
    logic [31:0] core_rdata;
    logic        retire_pulse = 1'b0;
    logic [31:0] status_word;

    int checks = 0;
    int failures = 0;

    // Reference model state
    logic [31:0] m_rx = '0, m_tx = '0;
    logic        m_rxf = 0, m_txf = 0, m_adv = 0;

    always #2 clk = ~clk;

    dbg_mailbox i_dbg_mailbox (
        .clk(clk), .rst_n(rst_n),
        .dbg_valid(dbg_valid), .dbg_write(dbg_write), .dbg_sel(dbg_sel),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .core_valid(core_valid), .core_write(core_write),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .retire_pulse(retire_pulse), .status_word(status_word)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] w = '0;
        w[30] = m_rxf;
        w[29] = m_txf;
        w[25] = m_adv;
        return w;
    endfunction

    // One clock: drive at negedge, compare before posedge, advance model at posedge
    task automatic cyc(input logic dv, input logic dw, input logic [1:0] sel,
                       input logic [31:0] wd, input logic cv, input logic cw,
                       input logic [31:0] cwd, input logic ret, input string tag);
        logic [31:0] e_dbg;
        @(negedge clk);
        dbg_valid = dv; dbg_write = dw; dbg_sel = sel; dbg_wdata = wd;
        core_valid = cv; core_write = cw; core_wdata = cwd; retire_pulse = ret;
        #1;
        e_dbg = 32'h0;
        if (dv && !dw) begin
            case (sel)
                2'd0: e_dbg = m_rx;
                2'd1: e_dbg = m_tx;
                2'd2: e_dbg = exp_status();
                default: e_dbg = 32'h0;
            endcase
        end
        chk(tag, "status_word", status_word, exp_status());
        chk(tag, "core_rdata", core_rdata, m_rx);
        chk(tag, "dbg_rdata", dbg_rdata, e_dbg);
        @(posedge clk);
        if (dv && dw && sel == 2'd0) begin m_rx = wd; m_rxf = 1; end
        else if (cv && !cw) m_rxf = 0;
        if (cv && cw) begin m_tx = cwd; m_txf = 1; end
        else if (dv && !dw && sel == 2'd1) m_txf = 0;
        if (ret) m_adv = 1;
        else if (dv && dw && sel == 2'd3 && wd[3]) m_adv = 0;
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 2'd0, 32'h0, 0, 0, 32'h0, 0, tag);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL R1 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "status_word in reset", status_word, 32'h0);
        chk("R1", "core_rdata in reset", core_rdata, 32'h0);
        rst_n = 1'b1;
        idle("R1");
        // R2: debugger fills rx
        cyc(1, 1, 2'd0, 32'hA5A5_0001, 0, 0, 0, 0, "R2");
        idle("R2");
        cyc(1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 2'd3, 0, 0, 0, 0, 0, "R2");
        // R3: core drains rx, stale data remains
        cyc(0, 0, 2'd0, 0, 1, 0, 0, 0, "R3");
        idle("R3");
        cyc(0, 0, 2'd0, 0, 1, 0, 0, 0, "R3");
        // R4, R6, R5: tx path with overwrite
        cyc(0, 0, 2'd0, 0, 1, 1, 32'h1111_1111, 0, "R4");
        idle("R4");
        cyc(0, 0, 2'd0, 0, 1, 1, 32'h2222_2222, 0, "R6");
        idle("R6");
        cyc(1, 0, 2'd1, 0, 0, 0, 0, 0, "R5");
        idle("R5");
        // R7: sticky retire
        cyc(0, 0, 2'd0, 0, 0, 0, 0, 1, "R7");
        idle("R7");
        idle("R7");
        // R9/R10: status writes are inert, reserved bits zero
        cyc(1, 1, 2'd0, 32'h0000_0042, 0, 0, 0, 0, "R9");
        cyc(1, 1, 2'd2, 32'h0000_0000, 0, 0, 0, 0, "R9");
        cyc(1, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, "R9");
        cyc(1, 0, 2'd2, 0, 0, 0, 0, 0, "R10");
        // R8: run-control clear
        cyc(1, 1, 2'd3, 32'hFFFF_FFF7, 0, 0, 0, 0, "R8");
        idle("R8");
        cyc(1, 1, 2'd3, 32'h0000_0008, 0, 0, 0, 0, "R8");
        idle("R8");
        // R11: collisions
        cyc(1, 1, 2'd3, 32'h0000_0008, 0, 0, 0, 1, "R11");
        idle("R11");
        cyc(1, 1, 2'd0, 32'h0BAD_F00D, 1, 0, 0, 0, "R11");
        idle("R11");
        cyc(1, 0, 2'd1, 0, 1, 1, 32'h3333_3333, 0, "R11");
        idle("R11");
        cyc(1, 0, 2'd1, 0, 0, 0, 0, 0, "R11");
        // Random traffic, compared on every clock
        for (int i = 0; i < 400; i++) begin
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                2'($urandom_range(0, 3)), $urandom,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom, $urandom_range(0, 3) == 0, "R11");
        end
        idle("R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule